// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block makes the frame sync waveform for one audio serial cluster, for both TDM and two-channel serial formats. Each frame starts with a high phase and ends with a low phase. Each phase has its own programmable length, counted in bit-clock ticks. Because the two lengths are held separately, a frame of any length R, odd or even, can be built with the duty cycle as close to half as the integer split allows. The serializers attached to the cluster get the sync level and a one-cycle frame-start strobe, which marks the first high tick of every frame.

Everything runs on one system clock. Each possible bit-clock source arrives as a per-cycle tick qualifier on `srcTick`, and a select register picks which source advances the generator. A small write/read register port holds five things: the cluster clock enable, the generator enable, the source select and the two phase lengths. The generator runs only while both enable bits are set. New phase lengths are copied into working copies at a frame boundary, so reprogramming never cuts a frame short.

Top module: `frame_sync_gen`

## Requirements
- R1: After reset every register reads as zero, and `fsync` and `frameStart` are low.
- R2: A high-phase register value N gives a high phase of exactly N+1 selected ticks.
- R3: A low-phase register value M gives a low phase of exactly M+1 selected ticks.
- R4: For a frame length R ≥ 2, programming high = R/2−1 and low = (R+1)/2−1 gives a frame of exactly R ticks. The low phase is one tick longer when R is odd, and the two phases are equal when R is even.
- R5: A select value of k+1 (held in register 2, bits [3:0]) makes `srcTick[k]` the tick source. A value of 0, or any value above the number of sources, selects no source, and `fsync` then never rises. When the selected tick is low, `fsync` holds its level.
- R6: While the generator enable (register 1, bit 0) is clear, `fsync` and `frameStart` stay low and the phase counter is held in reset. After a fresh enable the first frame has the full programmed high length.
- R7: While the cluster clock enable (register 0, bit 0) is clear, the generator is stopped in the same way, even if the generator enable is set.
- R8: On the first selected tick after the generator starts, `fsync` goes high. `frameStart` pulses for exactly one clock cycle on the first high cycle of every frame and at no other time.
- R9: A write to the high- or low-phase register during a frame leaves the current frame's lengths unchanged. The new value applies from the next frame on.
- R10: Reads return the stored register value in the low bits (phase lengths at register 3 for high and 4 for low, CNT_W bits wide), and unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | DATA_W | Register read data (combinational) |
| srcTick | input | NUM_SRC | Per-source bit-clock tick qualifiers |
| fsync | output | 1 | Frame sync level |
| frameStart | output | 1 | One-cycle pulse on the first high cycle of a frame |

## Verification
The bench builds the block with CNT_W = 4 and four tick sources. This makes it practical to sweep all 256 pairs of high and low values, so the counter's full range, including its wrap value, is measured over two consecutive frames for each pair. The same small width covers every frame length from 2 to 32 under the even-split rule. One source is slowed to a tick every third cycle, which shows that the select really routes that lane and that phase lengths scale with the tick rate and not with the clock.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CLK_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SYNC_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLK_SEL   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HI_LEN    = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_LO_LEN    = 3'd4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } fsg_phase_t;

  typedef struct packed {
    logic clear;
    logic startFrame;
    logic toLow;
    logic countUp;
  } fsg_strobe_t;

endpackage

// File: rtl/fsg_regs.sv
module fsg_regs #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [fsg_pkg::ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [fsg_pkg::ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0]         rdData,
  output logic                      mclkEn,
  output logic                      genEn,
  output logic [SEL_W-1:0]          clkSel,
  output logic [CNT_W-1:0]          hiLen,
  output logic [CNT_W-1:0]          loLen
);
  import fsg_pkg::*;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mclkEn <= 1'b0;
      genEn  <= 1'b0;
      clkSel <= '0;
      hiLen  <= '0;
      loLen  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CLK_STAT:  mclkEn <= wrData[0];
        ADDR_SYNC_STAT: genEn  <= wrData[0];
        ADDR_CLK_SEL:   clkSel <= wrData[SEL_W-1:0];
        ADDR_HI_LEN:    hiLen  <= wrData[CNT_W-1:0];
        ADDR_LO_LEN:    loLen  <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CLK_STAT:  rdData = DATA_W'(mclkEn);
      ADDR_SYNC_STAT: rdData = DATA_W'(genEn);
      ADDR_CLK_SEL:   rdData = DATA_W'(clkSel);
      ADDR_HI_LEN:    rdData = DATA_W'(hiLen);
      ADDR_LO_LEN:    rdData = DATA_W'(loLen);
      default:        rdData = '0;
    endcase
  end

endmodule

// File: rtl/fsg_src_mux.sv
module fsg_src_mux #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 4
) (
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic [SEL_W-1:0]   clkSel,
  output logic               tick
);
  logic [NUM_SRC-1:0] laneHit;

  // Select code 0 means no source; code k+1 picks lane k.
  for (genvar g = 0; g < NUM_SRC; g++) begin : gLane
    assign laneHit[g] = srcTick[g] && (clkSel == SEL_W'(g + 1));
  end

  assign tick = |laneHit;

endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 run,
  input  logic                 tick,
  input  logic                 hiDone,
  input  logic                 loDone,
  output fsg_pkg::fsg_strobe_t strb,
  output logic                 fsync,
  output logic                 frameStart
);
  import fsg_pkg::*;

  fsg_phase_t phase;

  always_comb begin
    strb = '0;
    if (!run) begin
      strb.clear = 1'b1;
    end else if (tick) begin
      case (phase)
        PH_IDLE: strb.startFrame = 1'b1;
        PH_HIGH: begin
          if (hiDone) strb.toLow   = 1'b1;
          else        strb.countUp = 1'b1;
        end
        PH_LOW: begin
          if (loDone) strb.startFrame = 1'b1;
          else        strb.countUp    = 1'b1;
        end
        default: strb.clear = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      frameStart <= 1'b0;
    end else begin
      frameStart <= strb.startFrame;
      if (strb.clear)           phase <= PH_IDLE;
      else if (strb.startFrame) phase <= PH_HIGH;
      else if (strb.toLow)      phase <= PH_LOW;
    end
  end

  assign fsync = (phase == PH_HIGH);

endmodule

// File: rtl/fsg_datapath.sv
module fsg_datapath #(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fsg_pkg::fsg_strobe_t strb,
  input  logic [CNT_W-1:0]     hiLen,
  input  logic [CNT_W-1:0]     loLen,
  output logic                 hiDone,
  output logic                 loDone
);
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] hiShadow;
  logic [CNT_W-1:0] loShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      hiShadow <= '0;
      loShadow <= '0;
    end else if (strb.clear || strb.toLow) begin
      phaseCnt <= '0;
    end else if (strb.startFrame) begin
      phaseCnt <= '0;
      hiShadow <= hiLen;
      loShadow <= loLen;
    end else if (strb.countUp) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign hiDone = (phaseCnt == hiShadow);
  assign loDone = (phaseCnt == loShadow);

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 8,
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [fsg_pkg::ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [fsg_pkg::ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0]          rdData,
  input  logic [NUM_SRC-1:0]         srcTick,
  output logic                       fsync,
  output logic                       frameStart
);
  import fsg_pkg::*;

  logic             mclkEn;
  logic             genEn;
  logic [SEL_W-1:0] clkSel;
  logic [CNT_W-1:0] hiLen;
  logic [CNT_W-1:0] loLen;
  logic             tick;
  logic             run;
  logic             hiDone;
  logic             loDone;
  fsg_strobe_t      strb;

  assign run = mclkEn && genEn;

  fsg_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .mclkEn(mclkEn), .genEn(genEn),
    .clkSel(clkSel), .hiLen(hiLen), .loLen(loLen)
  );

  fsg_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .srcTick(srcTick), .clkSel(clkSel), .tick(tick)
  );

  fsg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .tick(tick), .hiDone(hiDone),
    .loDone(loDone), .strb(strb), .fsync(fsync), .frameStart(frameStart)
  );

  fsg_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hiLen(hiLen), .loLen(loLen),
    .hiDone(hiDone), .loDone(loDone)
  );

endmodule

// File: rtl/frame_sync_gen_checker.sv
module frame_sync_gen_checker (
  input logic clk,
  input logic rstN,
  input logic run,
  input logic tick,
  input logic fsync,
  input logic frameStart
);

  assert_start_in_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> fsync);

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  assert_rise_marks_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fsync) |-> frameStart);

  assert_stopped_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (!fsync && !frameStart));

  assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    (run && !tick) |=> ($stable(fsync) && !frameStart));

endmodule

bind frame_sync_gen frame_sync_gen_checker u_checker (
  .clk(clk), .rstN(rstN), .run(run), .tick(tick),
  .fsync(fsync), .frameStart(frameStart)
);

// File: tb/frame_sync_gen_bench.sv
module frame_sync_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W  = 16;
  localparam int CNT_W   = 4;
  localparam int NUM_SRC = 4;
  localparam int MAXV    = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [2:0]        wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [2:0]        rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic [NUM_SRC-1:0] srcTick = '1;
  logic              fsync;
  logic              frameStart;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int tickMode = 0;
  int divCnt = 0;

  frame_sync_gen #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) u_frame_sync_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .srcTick(srcTick),
    .fsync(fsync), .frameStart(frameStart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Tick sources: all lanes every cycle, or lane 2 every third cycle.
  initial forever begin
    @(negedge clk);
    divCnt = (divCnt + 1) % 3;
    if (tickMode == 0) srcTick = '1;
    else srcTick = {1'b1, (divCnt == 0), 2'b11};
  end

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [DATA_W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output int v);
    rdAddr = a;
    #1;
    v = int'(rdData);
  endtask

  // Counts high then low samples; caller may have consumed some high samples.
  task automatic measureFrame(input int already, output int h, output int l, output int starts);
    int guard = 0;
    starts = 0;
    if (already == 0)
      while (!fsync && guard < 600) begin @(negedge clk); guard++; end
    h = already; l = 0;
    while (fsync && guard < 600) begin
      if (frameStart) starts++;
      h++; @(negedge clk); guard++;
    end
    while (!fsync && guard < 600) begin
      if (frameStart) starts++;
      l++; @(negedge clk); guard++;
    end
  endtask

  task automatic enableWith(input int hi, input int lo, input int sel);
    writeReg(3'd1, 16'd0);
    writeReg(3'd2, DATA_W'(sel));
    writeReg(3'd3, DATA_W'(hi));
    writeReg(3'd4, DATA_W'(lo));
    writeReg(3'd0, 16'd1);
    writeReg(3'd1, 16'd1);
  endtask

  task automatic checkQuiet(input string req, input int cycles);
    int highs = 0;
    for (int i = 0; i < cycles; i++) begin
      if (fsync || frameStart) highs++;
      @(negedge clk);
    end
    check(req, highs, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, h, l, s, h2, l2, s2;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 fsync", int'(fsync), 0);
    check("R1 frameStart", int'(frameStart), 0);
    for (int a = 0; a < 5; a++) begin
      readReg(3'(a), v);
      check("R1 reg reset", v, 0);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R10 readback and unused bits
    writeReg(3'd3, 16'hFFFF); readReg(3'd3, v); check("R10 high width", v, MAXV);
    writeReg(3'd4, 16'hABC5); readReg(3'd4, v); check("R10 low width", v, 5);
    writeReg(3'd2, 16'h00F3); readReg(3'd2, v); check("R10 select width", v, 3);
    writeReg(3'd1, 16'hFFFE); readReg(3'd1, v); check("R10 enable bit0", v, 0);
    writeReg(3'd0, 16'h0001); readReg(3'd0, v); check("R10 clock status", v, 1);
    writeReg(3'd0, 16'h0000);

    // R2 R3 R8: exhaustive sweep of both phase lengths, two frames each
    for (int hi = 0; hi <= MAXV; hi++) begin
      for (int lo = 0; lo <= MAXV; lo++) begin
        enableWith(hi, lo, 1);
        measureFrame(0, h, l, s);
        check("R2 high length", h, hi + 1);
        check("R3 low length", l, lo + 1);
        check("R8 one strobe per frame", s, 1);
        check("R8 strobe at next start", int'(frameStart && fsync), 1);
        measureFrame(0, h2, l2, s2);
        check("R2 R3 repeat frame", h2 * 100 + l2, (hi + 1) * 100 + lo + 1);
      end
    end

    // R4 even and odd frame lengths
    for (int r = 2; r <= 2 * (MAXV + 1); r++) begin
      enableWith(r / 2 - 1, (r + 1) / 2 - 1, 1);
      measureFrame(0, h, l, s);
      check("R4 frame total", h + l, r);
      check("R4 low extra on odd", l - h, r % 2);
    end

    // R9 reprogramming mid-frame
    enableWith(3, 2, 1);
    measureFrame(0, h, l, s);
    writeReg(3'd3, 16'd7);
    writeReg(3'd4, 16'd6);
    measureFrame(2, h, l, s);
    check("R9 current high kept", h, 4);
    check("R9 current low kept", l, 3);
    measureFrame(0, h, l, s);
    check("R9 next high", h, 8);
    check("R9 next low", l, 7);

    // R6 disable mid-frame, then restart with full high phase
    enableWith(5, 5, 1);
    measureFrame(0, h, l, s);
    @(negedge clk); @(negedge clk);
    writeReg(3'd1, 16'd0);
    @(negedge clk);
    checkQuiet("R6 stopped low", 20);
    writeReg(3'd1, 16'd1);
    check("R6 not yet started", int'(fsync), 0);
    @(negedge clk);
    check("R8 high on first tick", int'(fsync), 1);
    check("R8 strobe on first tick", int'(frameStart), 1);
    measureFrame(0, h, l, s);
    check("R6 full first high", h, 6);

    // R7 cluster clock enable gates the generator
    writeReg(3'd0, 16'd0);
    @(negedge clk);
    checkQuiet("R7 clock off low", 20);
    writeReg(3'd0, 16'd1);
    @(negedge clk);
    check("R7 restart", int'(fsync && frameStart), 1);

    // R5 select: no source, out-of-range source, and slow lane 2
    enableWith(2, 2, 0);
    checkQuiet("R5 select zero", 30);
    enableWith(2, 2, NUM_SRC + 1);
    checkQuiet("R5 select out of range", 30);
    tickMode = 1;
    enableWith(2, 4, 3);
    measureFrame(0, h, l, s);
    measureFrame(0, h, l, s);
    check("R5 slow lane high", h, 3 * 3);
    check("R5 slow lane low", l, 3 * 5);
    check("R5 one strobe slow", s, 1);
    tickMode = 0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule